// File: doc/BRIEF.md
# Rounding Saturating FIR Dot-Product Engine

This block forms a 16-tap dot product of signed 32-bit samples and coefficients, both in 8.24 fixed point. A start strobe, taken while the engine is idle, begins a run. The engine then drives a tap index from 0 to 15 on consecutive cycles. External storage returns the matching sample and coefficient combinationally in the same cycle. The engine multiplies the two into a 64-bit signed product in 16.48 format. It adds that product into a 64-bit accumulator, one tap per cycle. There is no overflow check between taps. Coefficient magnitudes below one leave enough headroom that the 64-bit sum itself cannot wrap.

The accumulator does not start from zero. It is seeded with half of one output LSB, which is bit 23. Dropping the low 24 bits at the end therefore rounds to nearest instead of truncating. After the last tap the engine decides once whether the sum fits the 8.24 output.
- If it fits, the output is accumulator bits 55 down to 24.
- If it does not fit, the output is clamped to the most positive or most negative 32-bit value, following the accumulator's sign, and a saturation flag is raised.

The result appears with a one-cycle done pulse.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is held and after its release, done, sat, result and tap_idx are all zero until a run completes.
- R2: A start sampled high while idle begins a run. On the 16 cycles after that edge, tap_idx presents 0, 1, …, 15 in order, one value per cycle.
- R3: The accumulator is seeded with 2^23 when a run begins. On each tap cycle it adds the full 64-bit signed product of samp_in and coef_in, both read as two's complement. No overflow is checked between taps.
- R4: done is high for exactly one cycle. That cycle starts at the 16th rising edge after the edge that accepted start, and result and sat are valid on it.
- R5: When accumulator bits 63..55 are all equal, result on done equals accumulator bits 55..24.
- R6: When bits 63..55 are not all equal and bit 63 is 0, result is 0x7FFFFFFF and sat is 1.
- R7: When bits 63..55 are not all equal and bit 63 is 1, result is 0x80000000 and sat is 1.
- R8: sat is 0 on an in-range done, and sat is never high while done is low.
- R9: A start pulse while a run is in progress has no effect. tap_idx keeps stepping and done arrives at the original time with the original data's result.
- R10: A start given in the done cycle is accepted, so back-to-back runs are possible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| tap_idx | output | 4 | Tap currently being accumulated |
| samp_in | input | 32 | Signed 8.24 sample for tap_idx |
| coef_in | input | 32 | Signed 8.24 coefficient for tap_idx |
| result | output | 32 | Rounded or clamped 8.24 result |
| sat | output | 1 | Result was clamped (valid with done) |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench drives products that sit exactly on the rounding boundary, both just above and just below one half LSB and with negative sign. A design that seeded the accumulator with zero, or used the wrong seed bit, would return values off by one LSB. Sums are pushed just past both ends of the 8.24 range. A wrong range-test bit window or a clamp chosen by the wrong sign would give a wrapped value, or the opposite extreme. A start is also injected mid-run and in the done cycle. An engine that restarted while busy would shift done and corrupt the sum. One that refused a start on the done cycle would drop the second run.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FRAC_W  = 24;
  localparam int unsigned ACC_W   = 2 * WORD_W;
  localparam int unsigned KEEP_HI = FRAC_W + WORD_W - 1;   // top bit of kept slice
  localparam int unsigned GUARD_W = ACC_W - KEEP_HI;       // bits that must agree

  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic        [WORD_W-1:0] word_t;

  // half-LSB of the kept slice, high word zero
  function automatic acc_t round_seed();
    acc_t r;
    r = '0;
    r[FRAC_W-1] = 1'b1;
    return r;
  endfunction

  function automatic acc_t mac_step(acc_t acc, word_t s, word_t c);
    acc_t se, ce;
    se = acc_t'($signed(s));
    ce = acc_t'($signed(c));
    return acc + se * ce;
  endfunction

  function automatic logic slice_fits(acc_t a);
    logic [GUARD_W-1:0] g;
    g = a[ACC_W-1:KEEP_HI];
    return (&g) | (~|g);
  endfunction

  function automatic word_t take_slice(acc_t a);
    return a[KEEP_HI:FRAC_W];
  endfunction

  function automatic word_t clamp_value(logic neg);
    return neg ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl #(
  parameter int unsigned TAPS  = 16,
  parameter int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] tap_idx,
  output logic             load,
  output logic             step,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  assign load = start & ~busy;
  assign step = busy;
  assign last = busy & (tap_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tap_idx <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      tap_idx <= '0;
    end else if (busy) begin
      if (last) begin
        busy    <= 1'b0;
        tap_idx <= '0;
      end else begin
        tap_idx <= tap_idx + 1'b1;
      end
    end
  end

  // R2
  tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && tap_idx == $past(tap_idx) + 1'b1));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && start) |=> (tap_idx != '0));
endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc
  import fir_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  word_t samp,
  input  word_t coef,
  output acc_t  acc_q,
  output acc_t  acc_next
);
  assign acc_next = mac_step(acc_q, samp, coef);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= round_seed();
    else if (step) acc_q <= acc_next;
  end

  // R3
  seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == round_seed()));
endmodule

// File: rtl/fir_sat_out.sv
module fir_sat_out
  import fir_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  acc_t  acc_final,
  output word_t result,
  output logic  sat,
  output logic  done
);
  logic  fits;
  word_t pick;

  always_comb begin
    fits = slice_fits(acc_final);
    pick = fits ? take_slice(acc_final) : clamp_value(acc_final[ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      sat    <= 1'b0;
      result <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        sat    <= ~fits;
        result <= pick;
      end else begin
        sat    <= 1'b0;
      end
    end
  end

  // R4
  done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  sat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> done);

  // R6 R7
  clamp_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sat) |-> (result == 32'h7FFF_FFFF || result == 32'h8000_0000));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int unsigned TAPS  = 16,
  parameter int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [IDX_W-1:0]  tap_idx,
  input  logic [WORD_W-1:0] samp_in,
  input  logic [WORD_W-1:0] coef_in,
  output logic [WORD_W-1:0] result,
  output logic              sat,
  output logic              done
);
  logic busy, load, step, last;
  acc_t acc_q, acc_next;

  fir_tap_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .tap_idx(tap_idx), .load(load), .step(step), .last(last)
  );

  fir_mac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .samp(samp_in), .coef(coef_in), .acc_q(acc_q), .acc_next(acc_next)
  );

  fir_sat_out u_out (
    .clk(clk), .rst_n(rst_n), .fire(last), .acc_final(acc_next),
    .result(result), .sat(sat), .done(done)
  );

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tap_idx == IDX_W'(TAPS - 1)) |=> (done && !busy));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && tap_idx == '0));
endmodule

// File: tb/test_fir_mac_engine.sv
module test_fir_mac_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  tap_idx;
  logic [31:0] samp_in, coef_in, result;
  logic sat, done;
  logic [31:0] smem [NT];
  logic [31:0] cmem [NT];

  assign samp_in = smem[tap_idx];
  assign coef_in = cmem[tap_idx];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_mac_engine i_fir_mac_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_idx(tap_idx),
    .samp_in(samp_in), .coef_in(coef_in), .result(result), .sat(sat), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 0;
  bit m_busy = 0, m_done = 0;
  int m_left = 0;
  logic [31:0] m_res;
  logic m_sat;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural expectation: exact integer sum, then range by arithmetic
  task automatic predict();
    longint sum, top;
    sum = longint'(1) << 23;
    for (int i = 0; i < NT; i++)
      sum += longint'($signed(smem[i])) * longint'($signed(cmem[i]));
    top = sum >>> 55;
    if (top == 0 || top == -1) begin
      m_res = sum[55:24];
      m_sat = 1'b0;
    end else if (sum < 0) begin
      m_res = 32'h8000_0000;
      m_sat = 1'b1;
    end else begin
      m_res = 32'h7FFF_FFFF;
      m_sat = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_busy = 1; m_left = NT;
        predict();
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R4 done", {31'd0, done}, {31'd0, m_done});
      if (m_done) begin
        chk(m_sat ? "R6/R7 clamp" : "R5 slice", result, m_res);
        chk("R8 sat", {31'd0, sat}, {31'd0, m_sat});
      end else begin
        chk("R8 sat idle", {31'd0, sat}, 32'd0);
      end
      if (m_busy) chk("R2 tap_idx", {28'd0, tap_idx}, 32'(NT - m_left));
    end
  end

  task automatic fill(logic [31:0] s, logic [31:0] c);
    for (int i = 0; i < NT; i++) begin smem[i] = s; cmem[i] = c; end
  endtask

  task automatic run_one();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NT + 2) @(negedge clk);
  endtask

  initial begin
    fill(32'd0, 32'd0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 sat", {31'd0, sat}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 tap_idx", {28'd0, tap_idx}, 32'd0);
    rst_n = 1'b1;
    chk_on = 1;
    @(negedge clk);
    chk("R1 result after release", result, 32'd0);

    // R3 zero inputs: only the seed
    fill(32'd0, 32'd0); run_one();
    // R3 R5 1.0 * 1/16 over 16 taps = 1.0
    fill(32'h0100_0000, 32'h0010_0000); run_one();
    // R3 rounding boundary: one tap worth exactly half LSB rounds up
    fill(32'd0, 32'd0); smem[3] = 32'd1; cmem[3] = 32'h0080_0000; run_one();
    // just below half LSB rounds down
    fill(32'd0, 32'd0); smem[7] = 32'd1; cmem[7] = 32'h007F_FFFF; run_one();
    // negative half LSB cancels the seed
    fill(32'd0, 32'd0); smem[15] = 32'hFFFF_FFFF; cmem[15] = 32'h0080_0000; run_one();
    // R6 positive overflow
    fill(32'h7F00_0000, 32'h7F00_0000); run_one();
    // R7 negative overflow
    fill(32'h8000_0000, 32'h7FFF_FFFF); run_one();
    // R5 edge just in range: 127.x
    fill(32'h7F00_0000, 32'h0010_0000); run_one();
    // R5 mixed signs
    for (int i = 0; i < NT; i++) begin
      smem[i] = (i % 2) ? 32'hFE80_0000 : 32'h0240_0000;
      cmem[i] = 32'h0000_0000 + 32'(i * 32'h0009_1000);
    end
    run_one();

    // R9 start while busy is ignored
    fill(32'h0030_0000, 32'h00C0_0000);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NT) @(negedge clk);

    // R10 back-to-back: restart in the done cycle
    fill(32'h0200_0000, 32'hFFF0_0000);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NT) @(negedge clk);
    fill(32'hFD00_0000, 32'h0050_0000);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NT + 2) @(negedge clk);

    // pseudo-random runs
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < NT; i++) begin
        smem[i] = $urandom;
        cmem[i] = (r % 2) ? $urandom : {{8{1'b0}}, 24'($urandom)};
      end
      run_one();
    end

    chk_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule